// File: doc/BRIEF.md
# Multi-Source Interrupt Aggregator Register Block

This block gathers level requests from up to 32 on-chip peripheral sources of a multi-function I/O device and turns them into interrupt messages for the processor. Each source input goes through edge detection. A new rising edge is always recorded in a pending register. When the source is also enabled in the mask, the edge is recorded in a request register and the block posts a single bus write message. The message address and the message data both come from one programmable register: the address is that register with its five low bits cleared, and the data is those five low bits.

Software reaches the block through a 32-bit register port. Each access receives its response one cycle later, and an unknown offset returns an error response. The register space also holds an error-log word, an arbitration-mask word, a seconds clock with a writable offset, and a power-control word that can raise a power-off request. Outgoing messages use a valid/ready handshake. If a message stalls, one further message waits in a holding slot.

Top module: `mioIrqTop`

## Requirements
- R1: After reset the request (0x00), mask (0x04), pending (0x08) and control (0x0C) registers read zero. The message-address register (0x10) reads CPU_BASE+3. msgValid and powerOffReq are low.
- R2: A rising edge on srcReq[n] sets pending bit n whatever the mask holds. A level held high counts as a single edge.
- R3: A rising edge on srcReq[n] with mask bit n set does two things. It sets request bit n. It also places one message on the output in the next cycle, with msgAddr = message-address & ~31 and msgData = message-address & 31.
- R4: While control bit 8 is set, a masked edge still sets its request bit, but no message is produced.
- R5: A read of the pending register returns its contents and then clears it. A write to it clears it, whatever the data. An edge that arrives in the same cycle as the clear stays pending.
- R6: The control register reads back only bit 8. Every other bit reads 0.
- R7: The mask keeps only the legal source bits 0x043F63A0 (bits 5, 7, 8, 9, 13, 14, 16–21 and 26). All other written bits are dropped.
- R8: Writes to the request register (0x00) and the version register (0xC008) have no effect. Power control (0xC000), version and I/O reset (0xC00C) read zero. Error log (0xC004) and arbitration mask (0xC010) read back what was written.
- R9: Writing exactly 0x00000002 to 0xC000 raises powerOffReq, and it stays high until reset. Any other value leaves it unchanged.
- R10: The clock register (0x9000) reads a seconds count plus an offset, and the count advances once every CLK_PER_SEC cycles. A write makes the next read return the written value.
- R11: An access to any offset not listed here responds with rspError=1 and rspData=0, and it changes no register.
- R12: While msgReady is low, msgValid, msgAddr and msgData hold steady. One further message, with the address and data current at its edge, is kept in a holding slot. Messages beyond that are dropped. Held messages leave in order.
- R13: Every access gets exactly one response, with rspValid high in the cycle after regValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWrData | input | DATA_W | Write data |
| rspValid | output | 1 | Response valid, one cycle after the access |
| rspData | output | DATA_W | Read data (zero for writes and errors) |
| rspError | output | 1 | Offset was not recognised |
| srcReq | input | DATA_W | Level request lines from the sources |
| msgValid | output | 1 | Interrupt message valid |
| msgAddr | output | DATA_W | Message write address |
| msgData | output | DATA_W | Message write data |
| msgReady | input | 1 | Fabric accepts the message |
| powerOffReq | output | 1 | Sticky power-off request |

## Verification
The collision that matters here is between a software clear of the pending register and a new source edge. Both land on the pending register on the same clock edge. The bench issues a pending read in the same cycle that raises a new source line. It then checks two things: the response carries only the bits set earlier, and a second read shows the new bit alone. A second overlap is a message stall that coincides with further masked edges and a change of the message address. There the bench checks the order, addresses and data of the messages that leave once msgReady returns.

// File: rtl/mioIrqPkg.sv
package mioIrqPkg;

  localparam int OFS_REQ     = 'h00000;
  localparam int OFS_MASK    = 'h00004;
  localparam int OFS_PEND    = 'h00008;
  localparam int OFS_CTL     = 'h0000C;
  localparam int OFS_MSGA    = 'h00010;
  localparam int OFS_CLOCK   = 'h09000;
  localparam int OFS_POWER   = 'h0C000;
  localparam int OFS_ERRLOG  = 'h0C004;
  localparam int OFS_VERSION = 'h0C008;
  localparam int OFS_IORST   = 'h0C00C;
  localparam int OFS_ARB     = 'h0C010;

  localparam int BUSERR_BIT  = 8;
  localparam int POWER_OFF_CODE = 2;

  typedef enum logic [3:0] {
    SEL_ZERO,
    SEL_REQ,
    SEL_MASK,
    SEL_PEND,
    SEL_CTL,
    SEL_MSGA,
    SEL_CLOCK,
    SEL_ERRLOG,
    SEL_ARB
  } regSel_e;

  typedef struct packed {
    logic    wrMask;
    logic    wrCtl;
    logic    wrMsgAddr;
    logic    wrErrLog;
    logic    wrArb;
    logic    wrPower;
    logic    wrClock;
    logic    clrPend;
    regSel_e sel;
  } strobes_t;

endpackage

// File: rtl/mioIrqControl.sv
module mioIrqControl
  import mioIrqPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] rdData,
  output strobes_t          stb,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspError
);

  logic    hit;
  regSel_e sel;
  logic    isPend;
  logic    isWrite;

  always_comb begin
    hit    = 1'b1;
    sel    = SEL_ZERO;
    isPend = 1'b0;
    case (regAddr)
      ADDR_W'(OFS_REQ):     sel = SEL_REQ;
      ADDR_W'(OFS_MASK):    sel = SEL_MASK;
      ADDR_W'(OFS_PEND):    begin sel = SEL_PEND; isPend = 1'b1; end
      ADDR_W'(OFS_CTL):     sel = SEL_CTL;
      ADDR_W'(OFS_MSGA):    sel = SEL_MSGA;
      ADDR_W'(OFS_CLOCK):   sel = SEL_CLOCK;
      ADDR_W'(OFS_POWER):   sel = SEL_ZERO;
      ADDR_W'(OFS_ERRLOG):  sel = SEL_ERRLOG;
      ADDR_W'(OFS_VERSION): sel = SEL_ZERO;
      ADDR_W'(OFS_IORST):   sel = SEL_ZERO;
      ADDR_W'(OFS_ARB):     sel = SEL_ARB;
      default:              hit = 1'b0;
    endcase
  end

  assign isWrite = regValid && hit && regWrite;

  always_comb begin
    stb           = '0;
    stb.sel       = sel;
    stb.wrMask    = isWrite && (regAddr == ADDR_W'(OFS_MASK));
    stb.wrCtl     = isWrite && (regAddr == ADDR_W'(OFS_CTL));
    stb.wrMsgAddr = isWrite && (regAddr == ADDR_W'(OFS_MSGA));
    stb.wrErrLog  = isWrite && (regAddr == ADDR_W'(OFS_ERRLOG));
    stb.wrArb     = isWrite && (regAddr == ADDR_W'(OFS_ARB));
    stb.wrPower   = isWrite && (regAddr == ADDR_W'(OFS_POWER));
    stb.wrClock   = isWrite && (regAddr == ADDR_W'(OFS_CLOCK));
    // reads and writes both empty the pending register
    stb.clrPend   = regValid && isPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      rspError <= 1'b0;
    end else begin
      rspValid <= regValid;
      rspError <= regValid && !hit;
      rspData  <= (regValid && hit && !regWrite) ? rdData : '0;
    end
  end

endmodule

// File: rtl/mioIrqDatapath.sv
module mioIrqDatapath
  import mioIrqPkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter logic [DATA_W-1:0] LEGAL_MASK  = 32'h043F_63A0,
  parameter logic [DATA_W-1:0] MSGA_RESET  = 32'hFFFA_0003,
  parameter int              CLK_PER_SEC = 100_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] srcReq,
  output logic [DATA_W-1:0] rdData,
  output logic              fire,
  output logic [DATA_W-1:0] fireAddr,
  output logic [DATA_W-1:0] fireData,
  output logic              powerOffReq
);

  localparam logic [DATA_W-1:0] LOW_FIVE = DATA_W'(31);

  logic [DATA_W-1:0] srcPrev;
  logic [DATA_W-1:0] reqReg;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] pendReg;
  logic              busErr;
  logic [DATA_W-1:0] msgAddrReg;
  logic [DATA_W-1:0] errLogReg;
  logic [DATA_W-1:0] arbReg;
  logic [DATA_W-1:0] secCount;
  logic [DATA_W-1:0] clkOffset;
  logic              pwrOff;
  logic              secTick;

  logic [DATA_W-1:0] rise;
  logic [DATA_W-1:0] hits;

  assign rise     = srcReq & ~srcPrev;
  assign hits     = rise & maskReg;
  assign fire     = (|hits) && !busErr;
  assign fireAddr = msgAddrReg & ~LOW_FIVE;
  assign fireData = msgAddrReg & LOW_FIVE;
  assign powerOffReq = pwrOff;

  // seconds prescaler: a counter, or a tick on every cycle when one cycle is a second
  generate
    if (CLK_PER_SEC > 1) begin : gPrescale
      localparam int PRE_W = $clog2(CLK_PER_SEC);
      logic [PRE_W-1:0] preCnt;
      assign secTick = (preCnt == PRE_W'(CLK_PER_SEC - 1));
      always_ff @(posedge clk) begin
        if (!rstN)        preCnt <= '0;
        else if (secTick) preCnt <= '0;
        else              preCnt <= preCnt + 1'b1;
      end
    end else begin : gNoPrescale
      assign secTick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPrev    <= '0;
      reqReg     <= '0;
      maskReg    <= '0;
      pendReg    <= '0;
      busErr     <= 1'b0;
      msgAddrReg <= MSGA_RESET;
      errLogReg  <= '0;
      arbReg     <= '0;
      secCount   <= '0;
      clkOffset  <= '0;
      pwrOff     <= 1'b0;
    end else begin
      srcPrev  <= srcReq;
      reqReg   <= reqReg | hits;
      // a clear keeps edges seen on the same clock
      pendReg  <= stb.clrPend ? rise : (pendReg | rise);
      secCount <= secCount + DATA_W'(secTick);
      if (stb.wrMask)    maskReg    <= wrData & LEGAL_MASK;
      if (stb.wrCtl)     busErr     <= wrData[BUSERR_BIT];
      if (stb.wrMsgAddr) msgAddrReg <= wrData;
      if (stb.wrErrLog)  errLogReg  <= wrData;
      if (stb.wrArb)     arbReg     <= wrData;
      // offset compensates a tick on this very edge
      if (stb.wrClock)   clkOffset  <= wrData - (secCount + DATA_W'(secTick));
      if (stb.wrPower && wrData == DATA_W'(POWER_OFF_CODE)) pwrOff <= 1'b1;
    end
  end

  always_comb begin
    case (stb.sel)
      SEL_REQ:    rdData = reqReg;
      SEL_MASK:   rdData = maskReg;
      SEL_PEND:   rdData = pendReg;
      SEL_CTL:    rdData = DATA_W'(busErr) << BUSERR_BIT;
      SEL_MSGA:   rdData = msgAddrReg;
      SEL_CLOCK:  rdData = secCount + clkOffset;
      SEL_ERRLOG: rdData = errLogReg;
      SEL_ARB:    rdData = arbReg;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/mioIrqMsgQueue.sv
module mioIrqMsgQueue #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fire,
  input  logic [DATA_W-1:0] fireAddr,
  input  logic [DATA_W-1:0] fireData,
  input  logic              msgReady,
  output logic              msgValid,
  output logic [DATA_W-1:0] msgAddr,
  output logic [DATA_W-1:0] msgData
);

  logic              holdValid;
  logic [DATA_W-1:0] holdAddr;
  logic [DATA_W-1:0] holdData;
  logic              outFree;

  assign outFree = !msgValid || msgReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid  <= 1'b0;
      msgAddr   <= '0;
      msgData   <= '0;
      holdValid <= 1'b0;
      holdAddr  <= '0;
      holdData  <= '0;
    end else if (outFree) begin
      if (holdValid) begin
        msgValid  <= 1'b1;
        msgAddr   <= holdAddr;
        msgData   <= holdData;
        holdValid <= fire;
        if (fire) begin
          holdAddr <= fireAddr;
          holdData <= fireData;
        end
      end else begin
        msgValid <= fire;
        if (fire) begin
          msgAddr <= fireAddr;
          msgData <= fireData;
        end
      end
    end else if (fire && !holdValid) begin
      holdValid <= 1'b1;
      holdAddr  <= fireAddr;
      holdData  <= fireData;
    end
  end

endmodule

// File: rtl/mioIrqTop.sv
module mioIrqTop
  import mioIrqPkg::*;
#(
  parameter int              ADDR_W      = 20,
  parameter int              DATA_W      = 32,
  parameter logic [DATA_W-1:0] CPU_BASE    = 32'hFFFA_0000,
  parameter logic [DATA_W-1:0] LEGAL_MASK  = 32'h043F_63A0,
  parameter int              CLK_PER_SEC = 100_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspError,
  input  logic [DATA_W-1:0] srcReq,
  output logic              msgValid,
  output logic [DATA_W-1:0] msgAddr,
  output logic [DATA_W-1:0] msgData,
  input  logic              msgReady,
  output logic              powerOffReq
);

  localparam logic [DATA_W-1:0] MSGA_RESET = CPU_BASE + DATA_W'(3);

  strobes_t          stb;
  logic [DATA_W-1:0] rdData;
  logic              fire;
  logic [DATA_W-1:0] fireAddr;
  logic [DATA_W-1:0] fireData;

  mioIrqControl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .rdData(rdData), .stb(stb),
    .rspValid(rspValid), .rspData(rspData), .rspError(rspError)
  );

  mioIrqDatapath #(
    .DATA_W(DATA_W), .LEGAL_MASK(LEGAL_MASK),
    .MSGA_RESET(MSGA_RESET), .CLK_PER_SEC(CLK_PER_SEC)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData), .srcReq(srcReq),
    .rdData(rdData), .fire(fire), .fireAddr(fireAddr), .fireData(fireData),
    .powerOffReq(powerOffReq)
  );

  mioIrqMsgQueue #(.DATA_W(DATA_W)) uQueue (
    .clk(clk), .rstN(rstN), .fire(fire), .fireAddr(fireAddr),
    .fireData(fireData), .msgReady(msgReady), .msgValid(msgValid),
    .msgAddr(msgAddr), .msgData(msgData)
  );

endmodule

// File: rtl/mioIrqChecker.sv
module mioIrqChecker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regValid,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic              rspError,
  input logic              msgValid,
  input logic [DATA_W-1:0] msgAddr,
  input logic [DATA_W-1:0] msgData,
  input logic              msgReady,
  input logic              powerOffReq
);

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData))); // R12

  AST_MSG_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgAddr[4:0] == 5'd0) && (msgData[DATA_W-1:5] == '0)); // R3

  AST_PWR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |=> powerOffReq); // R9

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    regValid |=> rspValid); // R13

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspError) |-> (rspData == '0)); // R11

  AST_CTL_ONLY_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite && regAddr == ADDR_W'(12)) |=>
      ((rspData & ~(DATA_W'(1) << 8)) == '0)); // R6

endmodule

bind mioIrqTop mioIrqChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
  .regAddr(regAddr), .rspValid(rspValid), .rspData(rspData),
  .rspError(rspError), .msgValid(msgValid), .msgAddr(msgAddr),
  .msgData(msgData), .msgReady(msgReady), .powerOffReq(powerOffReq)
);

// File: tb/mioIrqTop_test.sv
`timescale 1ns/1ps
module mioIrqTop_test;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam logic [31:0] CPU_BASE = 32'hFFFA_0000;
  localparam int CPS = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regValid = 1'b0;
  logic              regWrite = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic              rspValid;
  logic [DATA_W-1:0] rspData;
  logic              rspError;
  logic [DATA_W-1:0] srcReq = '0;
  logic              msgValid;
  logic [DATA_W-1:0] msgAddr;
  logic [DATA_W-1:0] msgData;
  logic              msgReady = 1'b1;
  logic              powerOffReq;

  always #5 clk = ~clk;

  mioIrqTop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CPU_BASE(CPU_BASE),
              .CLK_PER_SEC(CPS)) uut (.*);

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // message beat log
  int beatCnt = 0;
  logic [31:0] beatAddr [16];
  logic [31:0] beatData [16];
  always @(posedge clk) begin
    if (rstN && msgValid && msgReady) begin
      beatAddr[beatCnt % 16] <= msgAddr;
      beatData[beatCnt % 16] <= msgData;
      beatCnt <= beatCnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [19:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    regValid = 1'b1; regWrite = wr; regAddr = a; regWrData = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    rd = rspData; er = rspError;
  endtask

  task automatic rdChk(input string req, input logic [19:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic er;
    access(1'b0, a, '0, rd, er);
    chk(req, rd, exp);
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    access(1'b1, a, d, rd, er);
  endtask

  typedef struct packed {
    logic        isWr;
    logic [19:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        expErr;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 20'h00000, 32'h0,          32'h0,          1'b0, 8'd1},
    '{1'b0, 20'h00004, 32'h0,          32'h0,          1'b0, 8'd1},
    '{1'b0, 20'h00008, 32'h0,          32'h0,          1'b0, 8'd1},
    '{1'b0, 20'h0000C, 32'h0,          32'h0,          1'b0, 8'd1},
    '{1'b0, 20'h00010, 32'h0,          32'hFFFA_0003,  1'b0, 8'd1},
    '{1'b1, 20'h00004, 32'hFFFF_FFFF,  32'h0,          1'b0, 8'd7},
    '{1'b0, 20'h00004, 32'h0,          32'h043F_63A0,  1'b0, 8'd7},
    '{1'b1, 20'h0000C, 32'hFFFF_FFFF,  32'h0,          1'b0, 8'd6},
    '{1'b0, 20'h0000C, 32'h0,          32'h0000_0100,  1'b0, 8'd6},
    '{1'b1, 20'h0000C, 32'h0000_0000,  32'h0,          1'b0, 8'd6},
    '{1'b0, 20'h0000C, 32'h0,          32'h0,          1'b0, 8'd6},
    '{1'b1, 20'h00000, 32'h0000_1234,  32'h0,          1'b0, 8'd8},
    '{1'b0, 20'h00000, 32'h0,          32'h0,          1'b0, 8'd8},
    '{1'b1, 20'h0C008, 32'h0000_0005,  32'h0,          1'b0, 8'd8},
    '{1'b0, 20'h0C008, 32'h0,          32'h0,          1'b0, 8'd8},
    '{1'b1, 20'h0C004, 32'hA5A5_0001,  32'h0,          1'b0, 8'd8},
    '{1'b0, 20'h0C004, 32'h0,          32'hA5A5_0001,  1'b0, 8'd8},
    '{1'b1, 20'h0C010, 32'h0000_0F0F,  32'h0,          1'b0, 8'd8},
    '{1'b0, 20'h0C010, 32'h0,          32'h0000_0F0F,  1'b0, 8'd8},
    '{1'b0, 20'h00014, 32'h0,          32'h0,          1'b1, 8'd11}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic er;
    int b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset outputs
    chk("R1 msgValid", {31'b0, msgValid}, 32'h0);
    chk("R1 powerOffReq", {31'b0, powerOffReq}, 32'h0);

    // vector table: R1 R6 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].isWr, VECS[i].addr, VECS[i].wdata, rd, er);
      chk($sformatf("R%0d vec%0d data", VECS[i].tag, i), rd, VECS[i].exp);
      chk($sformatf("R%0d vec%0d err", VECS[i].tag, i), {31'b0, er}, {31'b0, VECS[i].expErr});
    end
    // R13: response valid observed
    @(negedge clk); regValid = 1'b1; regAddr = 20'h0; regWrite = 1'b0;
    @(negedge clk); regValid = 1'b0;
    chk("R13 rspValid after access", {31'b0, rspValid}, 32'h1);
    @(negedge clk);
    chk("R13 rspValid idle", {31'b0, rspValid}, 32'h0);

    wr(20'h00010, 32'h0000_1234);
    rdChk("R11 msgaddr write", 20'h00010, 32'h0000_1234);
    // R11 unlisted write has no side effect
    access(1'b1, 20'h0001C, 32'hFFFF_FFFF, rd, er);
    chk("R11 error on write", {31'b0, er}, 32'h1);
    rdChk("R11 msgaddr intact", 20'h00010, 32'h0000_1234);
    rdChk("R11 pending intact", 20'h00008, 32'h0);

    // R2 R3: masked edge, held level
    b0 = beatCnt;
    @(negedge clk); srcReq[5] = 1'b1;
    @(negedge clk);
    chk("R3 msg next cycle", {31'b0, msgValid}, 32'h1);
    chk("R3 msg addr", msgAddr, 32'h0000_1220);
    chk("R3 msg data", msgData, 32'h0000_0014);
    repeat (4) @(negedge clk);
    chk("R2 held level one message", beatCnt - b0, 1);
    rdChk("R2 pending bit5", 20'h00008, 32'h0000_0020);
    rdChk("R5 pending cleared by read", 20'h00008, 32'h0);
    rdChk("R3 request bit5", 20'h00000, 32'h0000_0020);

    // R2 unmasked source
    b0 = beatCnt;
    @(negedge clk); srcReq[4] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 unmasked no message", beatCnt - b0, 0);
    rdChk("R2 unmasked pending", 20'h00008, 32'h0000_0010);
    rdChk("R2 unmasked request", 20'h00000, 32'h0000_0020);

    // R4 bus error suppresses message
    wr(20'h0000C, 32'h0000_0100);
    b0 = beatCnt;
    @(negedge clk); srcReq[7] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 no message", beatCnt - b0, 0);
    rdChk("R4 request bit7", 20'h00000, 32'h0000_00A0);
    rdChk("R4 pending bit7", 20'h00008, 32'h0000_0080);
    wr(20'h0000C, 32'h0);

    // R5 write clears
    @(negedge clk); srcReq[8] = 1'b1;
    repeat (2) @(negedge clk);
    wr(20'h00008, 32'h0);
    rdChk("R5 pending cleared by write", 20'h00008, 32'h0);

    // R5 same-cycle clear and new edge
    @(negedge clk); srcReq[13] = 1'b1;
    repeat (2) @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = 20'h00008; srcReq[9] = 1'b1;
    @(negedge clk); regValid = 1'b0;
    chk("R5 read returns prior bits", rspData, 32'h0000_2000);
    rdChk("R5 same-cycle edge survives", 20'h00008, 32'h0000_0200);

    // R12 stall, hold and drop
    wr(20'h00010, 32'h0000_1240);
    @(negedge clk); msgReady = 1'b0; srcReq[16] = 1'b1;
    repeat (2) @(negedge clk);
    wr(20'h00010, 32'h0000_1255);
    @(negedge clk); srcReq[17] = 1'b1;
    repeat (2) @(negedge clk); srcReq[18] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 stalled valid", {31'b0, msgValid}, 32'h1);
    chk("R12 stalled addr", msgAddr, 32'h0000_1240);
    chk("R12 stalled data", msgData, 32'h0);
    b0 = beatCnt;
    msgReady = 1'b1;
    repeat (5) @(negedge clk);
    chk("R12 two beats", beatCnt - b0, 2);
    chk("R12 first addr", beatAddr[b0 % 16], 32'h0000_1240);
    chk("R12 first data", beatData[b0 % 16], 32'h0);
    chk("R12 second addr", beatAddr[(b0 + 1) % 16], 32'h0000_1240);
    chk("R12 second data", beatData[(b0 + 1) % 16], 32'h0000_0015);

    // R9 power
    wr(20'h0C000, 32'h0000_0003);
    chk("R9 other value ignored", {31'b0, powerOffReq}, 32'h0);
    rdChk("R8 power reads zero", 20'h0C000, 32'h0);
    wr(20'h0C000, 32'h0000_0002);
    chk("R9 power off", {31'b0, powerOffReq}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R9 sticky", {31'b0, powerOffReq}, 32'h1);

    // R10 clock
    wr(20'h09000, 32'h0000_0100);
    rdChk("R10 readback", 20'h09000, 32'h0000_0100);
    repeat (3 * CPS) @(negedge clk);
    access(1'b0, 20'h09000, '0, rd, er);
    checks++;
    if (rd < 32'h102 || rd > 32'h104) begin
      failures++;
      $display("FAIL R10 advance actual=%h expected=%h..%h", rd, 32'h102, 32'h104);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule